// File: doc/BRIEF.md
# Shared Counter Slot Allocator for a 2x2 Pixel Group

A group of four pixels shares a small pool of counter blocks instead of owning one each. When a pixel's hit goes high, the allocator claims a free counter block for it. From then on that block's hit input is fed by its own select multiplexer from the chosen pixel. The selected pixel's index is held beside the block and is reported, joined to the group's fixed identifier, as the block's data tag. Because any pixel can use any free block, a pixel that fires again while its previous measurement is still being read out can start a new measurement at once, which cuts dead time.

Each block goes through three phases: free, measuring (while the owning pixel's hit stays high), and readout (after the hit falls, until the counter block signals done). A shared fast clock is enabled by the registered OR of all pixel hits and is delivered to each block through an AND with that block's measuring phase. Hits that find no free block are dropped and reported with a one-cycle overflow pulse.

Top module: `hit_slot_alloc`

## Requirements
- R1: After reset every block is free, `blk_busy_o`, `blk_hit_o`, `overflow_o`, `osc_en_o` and `blk_fclk_o` are all 0.
- R2: A pixel p whose hit is sampled high while it owns no block in measuring phase, and which is not marked dropped, makes the lowest-indexed free block busy in the next cycle. That block's tag field `blk_tag_o[b*TAG_W +: TAG_W]` then reads {GROUP_ID, p}, with the pixel index in the low PID_W bits, and the tag stays unchanged while the block is busy.
- R3: When several pixels request a block in the same cycle, they are served in ascending pixel index, each taking the lowest-indexed free block that remains.
- R4: `blk_hit_o[b]` equals the current `hit_i` bit of the block's recorded pixel while the block is measuring, and is 0 while the block is free or in readout.
- R5: A block in measuring phase moves to readout on the first clock edge at which its pixel's hit is sampled low. Until that edge the pixel is never given a second block.
- R6: A requesting pixel that finds no free block is dropped, and `overflow_o` is high for exactly the next cycle. A dropped pixel gets no block for as long as its hit stays high, even if a block becomes free.
- R7: A block in readout becomes free in the cycle after `blk_done_i[b]` is sampled high. A done pulse while the block is free or measuring has no effect.
- R8: `osc_en_o` is the OR of all `hit_i` bits sampled at the previous edge. `blk_fclk_o[b]` equals `fast_clk_i & osc_en_o & (block b measuring)`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hit_i | input | NPIX | Per-pixel hit level, synchronous to clk |
| blk_done_i | input | NBLK | Per-block readout-complete handshake |
| fast_clk_i | input | 1 | Shared fast measurement clock |
| blk_hit_o | output | NBLK | Multiplexed hit delivered to each counter block |
| blk_busy_o | output | NBLK | Block is measuring or awaiting readout |
| blk_tag_o | output | NBLK*TAG_W | Per block {GROUP_ID, pixel index} |
| overflow_o | output | 1 | One-cycle pulse after a hit was dropped |
| osc_en_o | output | 1 | Enable for the shared fast clock source |
| blk_fclk_o | output | NBLK | Gated fast clock to each counter block |

## Verification
The bench builds the block with NPIX=4, NBLK=3 and GROUP_ID=7'h5B. With fewer blocks than pixels, overflow can be reached when all four pixels hold their hits. A non-default group value makes wrong tag concatenation visible. Random hit, done and fast-clock patterns then exercise readout blocks being reclaimed while other pixels re-fire.

// File: rtl/hsa_pkg.sv
package hsa_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_MEAS = 2'd1,
        SLOT_READ = 2'd2
    } slot_st_e;
endpackage

// File: rtl/hsa_assign.sv
// Fixed-priority assignment of requesting pixels to free counter slots.
module hsa_assign #(
    parameter int NPIX  = 4,
    parameter int NBLK  = 4,
    parameter int PID_W = 2
) (
    input  logic [NPIX-1:0]       req_i,
    input  logic [NBLK-1:0]       free_i,
    output logic [NBLK-1:0]       take_o,
    output logic [NBLK*PID_W-1:0] take_pix_o,
    output logic [NPIX-1:0]       drop_o
);
    logic [NBLK-1:0] avail;
    logic            placed;

    always_comb begin
        avail      = free_i;
        take_o     = '0;
        take_pix_o = '0;
        drop_o     = '0;
        placed     = 1'b0;
        for (int p = 0; p < NPIX; p++) begin
            placed = 1'b0;
            if (req_i[p]) begin
                for (int b = 0; b < NBLK; b++) begin
                    if (!placed && avail[b]) begin
                        avail[b]                       = 1'b0;
                        take_o[b]                      = 1'b1;
                        take_pix_o[b*PID_W +: PID_W]   = PID_W'(p);
                        placed                         = 1'b1;
                    end
                end
                if (!placed) begin
                    drop_o[p] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hsa_slot.sv
// One counter slot: phase register, pixel index memory and hit select.
module hsa_slot
    import hsa_pkg::*;
#(
    parameter int NPIX  = 4,
    parameter int PID_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic [PID_W-1:0] take_pix_i,
    input  logic [NPIX-1:0]  hit_i,
    input  logic             done_i,
    output logic             busy_o,
    output logic             meas_o,
    output logic [PID_W-1:0] pix_o,
    output logic             hit_o
);
    typedef struct packed {
        slot_st_e         st;
        logic [PID_W-1:0] pix;
    } slot_t;

    slot_t s_d, s_q;
    logic  hit_sel;

    assign hit_sel = hit_i[s_q.pix];

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            SLOT_FREE: begin
                if (take_i) begin
                    s_d.st  = SLOT_MEAS;
                    s_d.pix = take_pix_i;
                end
            end
            SLOT_MEAS: begin
                if (!hit_sel) begin
                    s_d.st = SLOT_READ;
                end
            end
            SLOT_READ: begin
                if (done_i) begin
                    s_d.st = SLOT_FREE;
                end
            end
            default: s_d.st = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SLOT_FREE, pix: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = (s_q.st != SLOT_FREE);
    assign meas_o = (s_q.st == SLOT_MEAS);
    assign pix_o  = s_q.pix;
    assign hit_o  = meas_o & hit_sel;
endmodule

// File: rtl/hsa_fclk_gate.sv
// Shared fast clock enable and per-slot clock gating.
module hsa_fclk_gate #(
    parameter int NBLK = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            any_hit_i,
    input  logic [NBLK-1:0] meas_i,
    input  logic            fast_clk_i,
    output logic            osc_en_o,
    output logic [NBLK-1:0] fclk_o
);
    logic run_d, run_q;

    always_comb begin
        run_d = any_hit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else begin
            run_q <= run_d;
        end
    end

    assign osc_en_o = run_q;

    for (genvar b = 0; b < NBLK; b++) begin : g_gate
        assign fclk_o[b] = fast_clk_i & run_q & meas_i[b];
    end
endmodule

// File: rtl/hit_slot_alloc.sv
// Top: shares NBLK counter slots among NPIX pixel hits.
module hit_slot_alloc #(
    parameter int               NPIX     = 4,
    parameter int               NBLK     = 4,
    parameter int               GID_W    = 7,
    parameter logic [GID_W-1:0] GROUP_ID = 7'h2A,
    localparam int              PID_W    = (NPIX > 1) ? $clog2(NPIX) : 1,
    localparam int              TAG_W    = GID_W + PID_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPIX-1:0]       hit_i,
    input  logic [NBLK-1:0]       blk_done_i,
    input  logic                  fast_clk_i,
    output logic [NBLK-1:0]       blk_hit_o,
    output logic [NBLK-1:0]       blk_busy_o,
    output logic [NBLK*TAG_W-1:0] blk_tag_o,
    output logic                  overflow_o,
    output logic                  osc_en_o,
    output logic [NBLK-1:0]       blk_fclk_o
);
    typedef struct packed {
        logic [NPIX-1:0] drop;
        logic            ovf;
    } trk_t;

    trk_t                  t_d, t_q;
    logic [NBLK-1:0]       meas;
    logic [NBLK*PID_W-1:0] pix;
    logic [NPIX-1:0]       owned;
    logic [NPIX-1:0]       req;
    logic [NBLK-1:0]       take;
    logic [NBLK*PID_W-1:0] take_pix;
    logic [NPIX-1:0]       drop;

    // A pixel is owned while some slot is measuring it.
    always_comb begin
        owned = '0;
        for (int p = 0; p < NPIX; p++) begin
            for (int b = 0; b < NBLK; b++) begin
                if (meas[b] && (pix[b*PID_W +: PID_W] == PID_W'(p))) begin
                    owned[p] = 1'b1;
                end
            end
        end
    end

    assign req = hit_i & ~owned & ~t_q.drop;

    hsa_assign #(
        .NPIX (NPIX),
        .NBLK (NBLK),
        .PID_W(PID_W)
    ) assign_i (
        .req_i     (req),
        .free_i    (~blk_busy_o),
        .take_o    (take),
        .take_pix_o(take_pix),
        .drop_o    (drop)
    );

    for (genvar b = 0; b < NBLK; b++) begin : g_slot
        hsa_slot #(
            .NPIX (NPIX),
            .PID_W(PID_W)
        ) slot_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .take_i    (take[b]),
            .take_pix_i(take_pix[b*PID_W +: PID_W]),
            .hit_i     (hit_i),
            .done_i    (blk_done_i[b]),
            .busy_o    (blk_busy_o[b]),
            .meas_o    (meas[b]),
            .pix_o     (pix[b*PID_W +: PID_W]),
            .hit_o     (blk_hit_o[b])
        );
        assign blk_tag_o[b*TAG_W +: TAG_W] = {GROUP_ID, pix[b*PID_W +: PID_W]};
    end

    // Drop marks last while the hit stays high.
    always_comb begin
        t_d      = t_q;
        t_d.drop = hit_i & (t_q.drop | drop);
        t_d.ovf  = |drop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign overflow_o = t_q.ovf;

    hsa_fclk_gate #(
        .NBLK(NBLK)
    ) gate_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_hit_i (|hit_i),
        .meas_i    (meas),
        .fast_clk_i(fast_clk_i),
        .osc_en_o  (osc_en_o),
        .fclk_o    (blk_fclk_o)
    );
endmodule

// File: rtl/hsa_checker.sv
module hsa_checker #(
    parameter int NPIX  = 4,
    parameter int NBLK  = 4,
    parameter int PID_W = 2,
    parameter int TAG_W = 9
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NPIX-1:0]       hit_i,
    input logic [NBLK-1:0]       blk_done_i,
    input logic [NBLK-1:0]       blk_hit_o,
    input logic [NBLK-1:0]       blk_busy_o,
    input logic [NBLK*TAG_W-1:0] blk_tag_o,
    input logic                  overflow_o,
    input logic                  osc_en_o,
    input logic [NBLK-1:0]       blk_fclk_o
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= 1'b1;
        end
    end

    AST_OSC_FOLLOWS_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (osc_en_o == $past(|hit_i))); // R8

    AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en_o |-> (blk_fclk_o == '0)); // R8

    AST_OVF_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && overflow_o) |-> $past(|hit_i)); // R6

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        AST_CLAIM_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_q && $rose(blk_busy_o[b])) |-> $past(|hit_i)); // R2

        AST_TAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_q && blk_busy_o[b] && $past(blk_busy_o[b])) |->
                $stable(blk_tag_o[b*TAG_W +: TAG_W])); // R2

        AST_RELEASE_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_q && $fell(blk_busy_o[b])) |-> $past(blk_done_i[b])); // R7

        AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            !blk_busy_o[b] |-> !blk_hit_o[b]); // R4

        AST_IDLE_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
            !blk_busy_o[b] |-> !blk_fclk_o[b]); // R8

        for (genvar c = b + 1; c < NBLK; c++) begin : g_pair
            AST_NO_DUP_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
                (blk_hit_o[b] && blk_hit_o[c]) |->
                    (blk_tag_o[b*TAG_W +: PID_W] != blk_tag_o[c*TAG_W +: PID_W])); // R5
        end
    end
endmodule

bind hit_slot_alloc hsa_checker #(
    .NPIX (NPIX),
    .NBLK (NBLK),
    .PID_W(PID_W),
    .TAG_W(TAG_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_i     (hit_i),
    .blk_done_i(blk_done_i),
    .blk_hit_o (blk_hit_o),
    .blk_busy_o(blk_busy_o),
    .blk_tag_o (blk_tag_o),
    .overflow_o(overflow_o),
    .osc_en_o  (osc_en_o),
    .blk_fclk_o(blk_fclk_o)
);

// File: tb/hit_slot_alloc_tb_top.sv
module hit_slot_alloc_tb_top;
    localparam int         NPIX  = 4;
    localparam int         NBLK  = 3;
    localparam int         GID_W = 7;
    localparam logic [6:0] GID   = 7'h5B;
    localparam int         PID_W = 2;
    localparam int         TAG_W = GID_W + PID_W;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NPIX-1:0]       hit = '0;
    logic [NBLK-1:0]       done = '0;
    logic                  fck = 1'b0;
    logic [NBLK-1:0]       blk_hit;
    logic [NBLK-1:0]       blk_busy;
    logic [NBLK*TAG_W-1:0] blk_tag;
    logic                  ovf;
    logic                  osc;
    logic [NBLK-1:0]       fclk;

    int  errors = 0;
    int  checks = 0;
    bit  finished = 0;

    // Reference state: 0 free, 1 measuring, 2 readout.
    int              m_st [NBLK];
    int              m_pix[NBLK];
    logic [NPIX-1:0] m_drop;
    logic            m_ovf;
    logic            m_osc;

    always #2 clk = ~clk;

    hit_slot_alloc #(
        .NPIX    (NPIX),
        .NBLK    (NBLK),
        .GID_W   (GID_W),
        .GROUP_ID(GID)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (hit),
        .blk_done_i(done),
        .fast_clk_i(fck),
        .blk_hit_o (blk_hit),
        .blk_busy_o(blk_busy),
        .blk_tag_o (blk_tag),
        .overflow_o(ovf),
        .osc_en_o  (osc),
        .blk_fclk_o(fclk)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int b = 0; b < NBLK; b++) begin
            m_st[b]  = 0;
            m_pix[b] = 0;
        end
        m_drop = '0;
        m_ovf  = 1'b0;
        m_osc  = 1'b0;
    endtask

    task automatic model_next();
        logic [NPIX-1:0] req;
        logic [NPIX-1:0] drp;
        logic [NBLK-1:0] avail;
        int              nst [NBLK];
        int              npix[NBLK];
        bit              owned;
        bit              placed;
        req = '0;
        drp = '0;
        for (int p = 0; p < NPIX; p++) begin
            owned = 0;
            for (int b = 0; b < NBLK; b++)
                if (m_st[b] == 1 && m_pix[b] == p) owned = 1;
            req[p] = hit[p] && !owned && !m_drop[p];
        end
        for (int b = 0; b < NBLK; b++) begin
            avail[b] = (m_st[b] == 0);
            nst[b]   = m_st[b];
            npix[b]  = m_pix[b];
            if (m_st[b] == 1 && !hit[m_pix[b]]) nst[b] = 2;
            if (m_st[b] == 2 && done[b]) nst[b] = 0;
        end
        for (int p = 0; p < NPIX; p++) begin
            if (req[p]) begin
                placed = 0;
                for (int b = 0; b < NBLK; b++) begin
                    if (!placed && avail[b]) begin
                        avail[b] = 1'b0;
                        nst[b]   = 1;
                        npix[b]  = p;
                        placed   = 1;
                    end
                end
                if (!placed) drp[p] = 1'b1;
            end
        end
        for (int b = 0; b < NBLK; b++) begin
            m_st[b]  = nst[b];
            m_pix[b] = npix[b];
        end
        m_drop = hit & (m_drop | drp);
        m_ovf  = |drp;
        m_osc  = |hit;
    endtask

    task automatic compare_all();
        logic [NBLK-1:0] e_busy;
        logic [NBLK-1:0] e_hit;
        logic [NBLK-1:0] e_fclk;
        for (int b = 0; b < NBLK; b++) begin
            e_busy[b] = (m_st[b] != 0);
            e_hit[b]  = (m_st[b] == 1) && hit[m_pix[b]];
            e_fclk[b] = fck && m_osc && (m_st[b] == 1);
            if (m_st[b] != 0)
                chk("R2", $sformatf("tag blk%0d", b),
                    int'(blk_tag[b*TAG_W +: TAG_W]), int'({GID, 2'(m_pix[b])}));
        end
        chk("R7", "busy vector", int'(blk_busy), int'(e_busy));
        chk("R4", "block hit vector", int'(blk_hit), int'(e_hit));
        chk("R6", "overflow", int'(ovf), int'(m_ovf));
        chk("R8", "osc enable", int'(osc), int'(m_osc));
        chk("R8", "gated clocks", int'(fclk), int'(e_fclk));
    endtask

    task automatic step(input logic [NPIX-1:0] h, input logic [NBLK-1:0] d, input logic f);
        hit  = h;
        done = d;
        fck  = f;
        #1;
        compare_all();
        @(posedge clk);
        model_next();
        @(negedge clk);
    endtask

    function automatic int tag_pix(input int b);
        return int'(blk_tag[b*TAG_W +: PID_W]);
    endfunction

    initial begin
        #(4 * 60000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0C0FFEE5));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fck   = 1'b1;
        #1;
        // R1: idle outputs after reset
        chk("R1", "busy after reset", int'(blk_busy), 0);
        chk("R1", "hit after reset", int'(blk_hit), 0);
        chk("R1", "overflow after reset", int'(ovf), 0);
        chk("R1", "osc after reset", int'(osc), 0);
        chk("R1", "fclk after reset", int'(fclk), 0);
        @(negedge clk);

        // R2: lone hit on pixel 2 lands in block 0
        step(4'b0100, 3'b000, 1'b1);
        chk("R2", "blk0 busy", int'(blk_busy[0]), 1);
        chk("R2", "blk0 pixel", tag_pix(0), 2);
        chk("R2", "blk0 group", int'(blk_tag[TAG_W-1 -: GID_W]), int'(GID));

        // R3: pixels 1 and 3 together -> blocks 1 and 2 in order
        step(4'b1110, 3'b000, 1'b1);
        chk("R3", "blk1 pixel", tag_pix(1), 1);
        chk("R3", "blk2 pixel", tag_pix(2), 3);
        chk("R3", "all busy", int'(blk_busy), 7);

        // R5: held hits never claim a second block; R7: done while measuring ignored
        step(4'b1110, 3'b001, 1'b1);
        chk("R5", "blk0 still pixel 2", tag_pix(0), 2);
        chk("R7", "blk0 busy after early done", int'(blk_busy[0]), 1);

        // R6: pixel 0 fires with no free block
        step(4'b1111, 3'b000, 1'b1);
        chk("R6", "overflow pulse", int'(ovf), 1);
        step(4'b1111, 3'b000, 1'b1);
        chk("R6", "overflow one cycle", int'(ovf), 0);

        // pixel 1 releases -> block 1 readout, then done frees it
        step(4'b1101, 3'b000, 1'b1);
        chk("R5", "blk1 in readout busy", int'(blk_busy[1]), 1);
        chk("R4", "blk1 hit low in readout", int'(blk_hit[1]), 0);
        step(4'b1101, 3'b010, 1'b1);
        chk("R7", "blk1 freed", int'(blk_busy[1]), 0);
        step(4'b1101, 3'b000, 1'b1);
        chk("R6", "dropped pixel 0 not assigned", int'(blk_busy[1]), 0);

        // re-fire pixel 0 after release
        step(4'b1100, 3'b000, 1'b1);
        step(4'b1101, 3'b000, 1'b1);
        chk("R5", "pixel 0 gets block 1", int'(blk_busy[1]), 1);
        chk("R5", "blk1 pixel 0", tag_pix(1), 0);

        // R8: fast clock held low gives no gated clock
        hit = 4'b1101;
        fck = 1'b0;
        #1;
        chk("R8", "fclk with fast clock low", int'(fclk), 0);
        @(negedge clk);

        // everything releases and drains
        step(4'b0000, 3'b000, 1'b1);
        step(4'b0000, 3'b111, 1'b1);
        step(4'b0000, 3'b000, 1'b1);
        chk("R7", "all free after drain", int'(blk_busy), 0);
        chk("R8", "osc off when idle", int'(osc), 0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [NPIX-1:0] h;
            logic [NBLK-1:0] d;
            h = hit;
            for (int p = 0; p < NPIX; p++)
                if (($urandom % 6) == 0) h[p] = ~h[p];
            for (int b = 0; b < NBLK; b++)
                d[b] = (($urandom % 4) == 0);
            step(h, d, 1'($urandom % 2));
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule